// File: doc/BRIEF.md
# PCM Voice Serial Port

This block is the digital side of a per-channel voice codec. Once per 8 kHz frame it shifts one 8-bit PCM word out on a transmit data line and one word in from a receive data line. Each direction has its own bit clock and frame sync. All of these pins are treated as synchronous levels and sampled on a faster system clock. Every bit-clock or sync edge takes effect on the outputs two system-clock cycles after it occurs at the pins.

The port measures each sync pulse by counting the falling bit-clock edges that see the sync high. A pulse that spans one such edge selects short-frame timing. A pulse that spans two or more selects long-frame timing. The measured format governs the next frame, because a pulse's width is only known once the pulse has ended. The transmit sync sets the format for both directions. In receive half-channel mode the receive sync sets the receive format, and the transmitter stays silent.

The transmit output is tri-state, and it is qualified by an active-low time-slot indicator that is low for exactly the interval in which the output is driven. Each completed receive word is handed to the decoder with a one-cycle strobe when the next receive sync rises. Words travel most significant bit first: sign, then three chord bits, then four step bits.

Top module: `pcm_port`

## Requirements
- R1: After reset, tx_slot_n is 1, dec_start is 0, dec_word is 0, and the stored frame format for both directions is short.
- R2: A sync pulse seen high on exactly one falling bit-clock edge sets the short format. A pulse seen high on two or more falling edges (two included) sets the long format. The new format applies from the next sync pulse onward.
- R3: Short format, transmit: the falling bit-clock edge that finds tx_fsync high arms the port. On the next rising edge, tx_slot_n goes low and the MSB of tx_word is driven. Each of the following seven rising edges advances one bit.
- R4: Long format, transmit: tx_slot_n goes low and the MSB is driven as soon as tx_fsync and tx_bclk are both high. Each of the next seven rising edges advances one bit.
- R5: The output is released at the later of two events: the eighth falling bit-clock edge after enable, and the fall of tx_fsync. If the sync stays high longer, the last bit (LSB) stays driven until the sync falls.
- R6: tx_word is captured when the output is enabled. Bits leave MSB first, and the driven bit changes only after a rising bit-clock edge.
- R7: Long receive format: rx_data is sampled on the first eight falling rx_bclk edges after rx_fsync rises, MSB first.
- R8: Short receive format: the MSB is sampled on the second falling rx_bclk edge after rx_fsync rises, and the next seven falling edges take the remaining bits.
- R9: Each rising edge of rx_fsync produces a one-cycle dec_start pulse. dec_word then presents the last fully received word (0 if none) and holds it until the next pulse.
- R10: While rx_half is 1, the receive format comes from the rx_fsync width, and the transmit output never becomes enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_bclk | input | 1 | Transmit bit clock level |
| tx_fsync | input | 1 | Transmit frame sync level |
| tx_word | input | WORD_W | PCM word to send, captured at enable |
| tx_data | output | 1 | Serial transmit data, high impedance when not in slot |
| tx_slot_n | output | 1 | Active-low time-slot indicator (1 = released) |
| rx_bclk | input | 1 | Receive bit clock level |
| rx_fsync | input | 1 | Receive frame sync level |
| rx_data | input | 1 | Serial receive data |
| rx_half | input | 1 | Receive half-channel mode select |
| dec_start | output | 1 | One-cycle decode request on receive sync rise |
| dec_word | output | WORD_W | Word handed to the decoder |

## Verification
The assertions check the cycle-level invariants on every cycle:
- the driven bit never moves except after a rising bit-clock edge;
- the slot is only released once the sampled sync is low;
- enable happens only while the bit clock is high;
- half-channel mode keeps the slot released;
- the decode strobe lasts one cycle and the handed-over word holds between strobes.

Only the bench scenarios can show the frame-level behaviour. This covers the exact edge on which the slot opens and closes for each format, including the mixed case where the stored format disagrees with the current pulse. It also covers the extended-sync hold, the serial bit order in both directions, and the one-frame lag between a pulse's width and the timing it selects.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    localparam int PCM_WORD_W = 8;

    typedef enum logic {
        FMT_SHORT = 1'b0,
        FMT_LONG  = 1'b1
    } frame_fmt_e;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } line_ev_t;

endpackage

// File: rtl/pcm_edge_sampler.sv
module pcm_edge_sampler
    import pcm_port_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     bclk_i,
    input  logic     fs_i,
    input  logic     dat_i,
    output line_ev_t bclk_o,
    output line_ev_t fs_o,
    output logic     dat_o
);

    typedef struct packed {
        logic bclk;
        logic bclk_prev;
        logic fs;
        logic fs_prev;
        logic dat;
    } samp_t;

    samp_t samp_d, samp_q;

    always_comb begin
        samp_d           = samp_q;
        samp_d.bclk      = bclk_i;
        samp_d.bclk_prev = samp_q.bclk;
        samp_d.fs        = fs_i;
        samp_d.fs_prev   = samp_q.fs;
        samp_d.dat       = dat_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) samp_q <= '0;
        else        samp_q <= samp_d;
    end

    assign bclk_o.level = samp_q.bclk;
    assign bclk_o.rise  = samp_q.bclk & ~samp_q.bclk_prev;
    assign bclk_o.fall  = ~samp_q.bclk & samp_q.bclk_prev;
    assign fs_o.level   = samp_q.fs;
    assign fs_o.rise    = samp_q.fs & ~samp_q.fs_prev;
    assign fs_o.fall    = ~samp_q.fs & samp_q.fs_prev;
    assign dat_o        = samp_q.dat;

endmodule

// File: rtl/pcm_sync_width.sv
module pcm_sync_width
    import pcm_port_pkg::*;
#(
    parameter int LONG_MIN = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bclk_fall_i,
    input  logic       fs_level_i,
    input  logic       fs_fall_i,
    output frame_fmt_e fmt_o
);

    localparam int CNT_W = $clog2(LONG_MIN + 1);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(LONG_MIN);
    localparam logic [CNT_W-1:0] LONG_THR = CNT_W'(LONG_MIN);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        frame_fmt_e       fmt;
    } width_t;

    width_t wd_d, wd_q;

    always_comb begin
        wd_d = wd_q;
        if (fs_fall_i) begin
            if (wd_q.cnt != '0)
                wd_d.fmt = (wd_q.cnt >= LONG_THR) ? FMT_LONG : FMT_SHORT;
            wd_d.cnt = '0;
        end else if (bclk_fall_i && fs_level_i && wd_q.cnt != CNT_SAT) begin
            wd_d.cnt = wd_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wd_q.cnt <= '0;
            wd_q.fmt <= FMT_SHORT;
        end else begin
            wd_q <= wd_d;
        end
    end

    assign fmt_o = wd_q.fmt;

endmodule

// File: rtl/pcm_tx_slot.sv
module pcm_tx_slot
    import pcm_port_pkg::*;
#(
    parameter int WORD_W = PCM_WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  line_ev_t          bclk_i,
    input  logic              fs_level_i,
    input  frame_fmt_e        fmt_i,
    input  logic              block_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              drive_o,
    output logic              bit_o
);

    localparam int SH_W = $clog2(WORD_W);
    localparam int FL_W = $clog2(WORD_W + 1);
    localparam logic [SH_W-1:0] LAST_SHIFT = SH_W'(WORD_W - 1);
    localparam logic [FL_W-1:0] FALLS_DONE = FL_W'(WORD_W);
    localparam logic [FL_W-1:0] FALLS_LAST = FL_W'(WORD_W - 1);

    typedef struct packed {
        logic              active;
        logic              pend;
        logic              used;
        logic [WORD_W-1:0] sr;
        logic [SH_W-1:0]   shifts;
        logic [FL_W-1:0]   falls;
    } tx_t;

    tx_t tx_d, tx_q;
    logic start;
    logic done_now;

    always_comb begin
        tx_d  = tx_q;
        start = 1'b0;

        if (!fs_level_i) tx_d.used = 1'b0;

        if (block_i) begin
            tx_d.pend = 1'b0;
        end else if (!tx_q.active) begin
            if (tx_q.pend) begin
                start = bclk_i.rise;
            end else if (fmt_i == FMT_LONG) begin
                start = fs_level_i && bclk_i.level && !tx_q.used;
            end else if (bclk_i.fall && fs_level_i && !tx_q.used) begin
                tx_d.pend = 1'b1;
                tx_d.used = 1'b1;
            end
        end

        done_now = (tx_q.falls == FALLS_DONE) ||
                   (bclk_i.fall && tx_q.falls == FALLS_LAST);

        if (start) begin
            tx_d.active = 1'b1;
            tx_d.pend   = 1'b0;
            tx_d.used   = 1'b1;
            tx_d.sr     = word_i;
            tx_d.shifts = '0;
            tx_d.falls  = '0;
        end else if (tx_q.active) begin
            if (bclk_i.rise && tx_q.shifts != LAST_SHIFT) begin
                tx_d.sr     = {tx_q.sr[WORD_W-2:0], 1'b0};
                tx_d.shifts = tx_q.shifts + 1'b1;
            end
            if (bclk_i.fall && tx_q.falls != FALLS_DONE)
                tx_d.falls = tx_q.falls + 1'b1;
            if (done_now && !fs_level_i)
                tx_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign drive_o = tx_q.active;
    assign bit_o   = tx_q.sr[WORD_W-1];

endmodule

// File: rtl/pcm_rx_slot.sv
module pcm_rx_slot
    import pcm_port_pkg::*;
#(
    parameter int WORD_W = PCM_WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_fall_i,
    input  logic              fs_rise_i,
    input  logic              dat_i,
    input  frame_fmt_e        fmt_i,
    output logic              dec_start_o,
    output logic [WORD_W-1:0] dec_word_o
);

    localparam int CNT_W = $clog2(WORD_W + 3);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W + 2);

    typedef struct packed {
        frame_fmt_e        fmt;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] sr;
        logic [WORD_W-1:0] hold;
        logic [WORD_W-1:0] dec_word;
        logic              dec_start;
    } rx_t;

    rx_t rx_d, rx_q;
    logic [CNT_W-1:0] pos;
    logic [CNT_W-1:0] first_pos;
    logic [CNT_W-1:0] last_pos;

    always_comb begin
        rx_d           = rx_q;
        rx_d.dec_start = 1'b0;
        pos            = rx_q.cnt + 1'b1;
        first_pos      = (rx_q.fmt == FMT_LONG) ? CNT_W'(1) : CNT_W'(2);
        last_pos       = first_pos + CNT_W'(WORD_W - 1);

        if (fs_rise_i) begin
            rx_d.dec_start = 1'b1;
            rx_d.dec_word  = rx_q.hold;
            rx_d.cnt       = '0;
            rx_d.fmt       = fmt_i;
        end else if (bclk_fall_i && rx_q.cnt != CNT_MAX) begin
            rx_d.cnt = pos;
            if (pos >= first_pos && pos <= last_pos) begin
                rx_d.sr = {rx_q.sr[WORD_W-2:0], dat_i};
                if (pos == last_pos)
                    rx_d.hold = {rx_q.sr[WORD_W-2:0], dat_i};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q     <= '0;
            rx_q.fmt <= FMT_SHORT;
            rx_q.cnt <= CNT_MAX;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign dec_start_o = rx_q.dec_start;
    assign dec_word_o  = rx_q.dec_word;

endmodule

// File: rtl/pcm_port.sv
module pcm_port
    import pcm_port_pkg::*;
#(
    parameter int WORD_W   = PCM_WORD_W,
    parameter int LONG_MIN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_bclk,
    input  logic              tx_fsync,
    input  logic [WORD_W-1:0] tx_word,
    output logic              tx_data,
    output logic              tx_slot_n,
    input  logic              rx_bclk,
    input  logic              rx_fsync,
    input  logic              rx_data,
    input  logic              rx_half,
    output logic              dec_start,
    output logic [WORD_W-1:0] dec_word
);

    line_ev_t   tx_bclk_ev, tx_fs_ev, rx_bclk_ev, rx_fs_ev;
    logic       tx_dat_unused, rx_dat_s;
    frame_fmt_e tx_fmt, rx_own_fmt, rx_fmt;
    logic       tx_drive, tx_bit;
    logic       tx_b_rise, tx_fs_s, tx_bclk_s;

    pcm_edge_sampler u_tx_samp (
        .clk    (clk),
        .rst_n  (rst_n),
        .bclk_i (tx_bclk),
        .fs_i   (tx_fsync),
        .dat_i  (1'b0),
        .bclk_o (tx_bclk_ev),
        .fs_o   (tx_fs_ev),
        .dat_o  (tx_dat_unused)
    );

    pcm_edge_sampler u_rx_samp (
        .clk    (clk),
        .rst_n  (rst_n),
        .bclk_i (rx_bclk),
        .fs_i   (rx_fsync),
        .dat_i  (rx_data),
        .bclk_o (rx_bclk_ev),
        .fs_o   (rx_fs_ev),
        .dat_o  (rx_dat_s)
    );

    pcm_sync_width #(.LONG_MIN(LONG_MIN)) u_tx_width (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk_fall_i (tx_bclk_ev.fall),
        .fs_level_i  (tx_fs_ev.level),
        .fs_fall_i   (tx_fs_ev.fall),
        .fmt_o       (tx_fmt)
    );

    pcm_sync_width #(.LONG_MIN(LONG_MIN)) u_rx_width (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk_fall_i (rx_bclk_ev.fall),
        .fs_level_i  (rx_fs_ev.level),
        .fs_fall_i   (rx_fs_ev.fall),
        .fmt_o       (rx_own_fmt)
    );

    assign rx_fmt = rx_half ? rx_own_fmt : tx_fmt;

    pcm_tx_slot #(.WORD_W(WORD_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk_i     (tx_bclk_ev),
        .fs_level_i (tx_fs_ev.level),
        .fmt_i      (tx_fmt),
        .block_i    (rx_half),
        .word_i     (tx_word),
        .drive_o    (tx_drive),
        .bit_o      (tx_bit)
    );

    pcm_rx_slot #(.WORD_W(WORD_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk_fall_i (rx_bclk_ev.fall),
        .fs_rise_i   (rx_fs_ev.rise),
        .dat_i       (rx_dat_s),
        .fmt_i       (rx_fmt),
        .dec_start_o (dec_start),
        .dec_word_o  (dec_word)
    );

    assign tx_b_rise = tx_bclk_ev.rise;
    assign tx_fs_s   = tx_fs_ev.level;
    assign tx_bclk_s = tx_bclk_ev.level;
    assign tx_slot_n = ~tx_drive;
    assign tx_data   = tx_drive ? tx_bit : 1'bz;

endmodule

// File: rtl/pcm_port_chk.sv
module pcm_port_chk #(
    parameter int WORD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_slot_n,
    input logic              tx_bit,
    input logic              tx_rise,
    input logic              tx_fs_s,
    input logic              tx_bclk_s,
    input logic              rx_half,
    input logic              dec_start,
    input logic [WORD_W-1:0] dec_word
);

    assert_bit_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_slot_n && $past(!tx_slot_n) && !$past(tx_rise)) |-> $stable(tx_bit));

    assert_release_after_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_slot_n) |-> !$past(tx_fs_s));

    assert_enable_bclk_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_slot_n) |-> $past(tx_bclk_s));

    assert_half_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_half && tx_slot_n) |=> tx_slot_n);

    assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dec_start |=> !dec_start);

    assert_word_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_start |-> $stable(dec_word));

endmodule

bind pcm_port pcm_port_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_slot_n (tx_slot_n),
    .tx_bit    (tx_bit),
    .tx_rise   (tx_b_rise),
    .tx_fs_s   (tx_fs_s),
    .tx_bclk_s (tx_bclk_s),
    .rx_half   (rx_half),
    .dec_start (dec_start),
    .dec_word  (dec_word)
);

// File: tb/pcm_port_tb.sv
module pcm_port_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bck = 1'b0;
    logic       tx_fsync = 1'b0;
    logic [7:0] tx_word = 8'h00;
    logic       tx_data;
    logic       tx_slot_n;
    logic       rx_fsync = 1'b0;
    logic       rx_data = 1'b0;
    logic       rx_half = 1'b0;
    logic       dec_start;
    logic [7:0] dec_word;

    int checks = 0;
    int fails = 0;
    int pulses = 0;
    bit done = 1'b0;

    bit         tx_fmt_m = 1'b0;
    bit         rx_fmt_m = 1'b0;
    logic [7:0] prev_rx = 8'h00;
    bit         prev_rx_long = 1'b0;
    bit         have_rx = 1'b0;

    always #10 clk = ~clk;

    pcm_port u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_bclk   (bck),
        .tx_fsync  (tx_fsync),
        .tx_word   (tx_word),
        .tx_data   (tx_data),
        .tx_slot_n (tx_slot_n),
        .rx_bclk   (bck),
        .rx_fsync  (rx_fsync),
        .rx_data   (rx_data),
        .rx_half   (rx_half),
        .dec_start (dec_start),
        .dec_word  (dec_word)
    );

    always @(negedge clk) if (rst_n && dec_start) pulses++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_drive(int p, bit hi, int s, int n, bit blocked);
        if (blocked || n == 0 || p < s) return 1'b0;
        if (hi) return (p <= s + 7) || (p < n);
        return (p <= s + 6) || (p < n);
    endfunction

    function automatic logic exp_bit(int p, int s, logic [7:0] w);
        int idx = p - s;
        if (idx > 7) idx = 7;
        return w[7 - idx];
    endfunction

    function automatic string tx_tag(int p, int s, bit long_f, bit blocked);
        if (blocked) return "R10";
        if (p - s >= 8) return "R5";
        return long_f ? "R4" : "R3";
    endfunction

    task automatic run_frame(input int txn, input logic [7:0] txw,
                             input int rxn, input logic [7:0] rxw, input bit half);
        int  s;
        int  rskip;
        bit  rx_eff;
        bit  e;
        int  pulses0;
        @(negedge clk);
        rx_half = half;
        tx_word = txw;
        s       = tx_fmt_m ? 0 : 1;
        rx_eff  = half ? rx_fmt_m : tx_fmt_m;
        rskip   = rx_eff ? 0 : 1;
        pulses0 = pulses;
        for (int p = 0; p < 14; p++) begin
            bck      = 1'b1;
            tx_fsync = (p < txn);
            rx_fsync = (p < rxn);
            rx_data  = (p - rskip >= 0 && p - rskip <= 7) ? rxw[7 - (p - rskip)] : 1'b0;
            repeat (6) @(negedge clk);
            e = exp_drive(p, 1'b1, s, txn, half);
            if (p == 0 && !half && txn > 0)
                chk(tx_slot_n == !e, "R2 stored format selects enable edge", tx_slot_n, !e);
            else
                chk(tx_slot_n == !e, tx_tag(p, s, tx_fmt_m, half), tx_slot_n, !e);
            if (e && !tx_slot_n)
                chk(tx_data == exp_bit(p, s, txw), "R6 bit order", tx_data, exp_bit(p, s, txw));
            if (p == 0 && rxn > 0) begin
                if (!have_rx)
                    chk(dec_word == 8'h00, "R1 first handover is zero", dec_word, 0);
                else if (half)
                    chk(dec_word == prev_rx, "R10 receive word", dec_word, prev_rx);
                else if (prev_rx_long)
                    chk(dec_word == prev_rx, "R7 long receive", dec_word, prev_rx);
                else
                    chk(dec_word == prev_rx, "R8 short receive", dec_word, prev_rx);
            end
            repeat (2) @(negedge clk);
            bck = 1'b0;
            repeat (6) @(negedge clk);
            e = exp_drive(p, 1'b0, s, txn, half);
            chk(tx_slot_n == !e, tx_tag(p, s, tx_fmt_m, half), tx_slot_n, !e);
            if (e && !tx_slot_n)
                chk(tx_data == exp_bit(p, s, txw), "R6 bit held low phase", tx_data, exp_bit(p, s, txw));
            repeat (2) @(negedge clk);
        end
        chk((pulses - pulses0) == (rxn > 0 ? 1 : 0), "R9 one strobe per sync",
            pulses - pulses0, rxn > 0 ? 1 : 0);
        if (txn > 0) tx_fmt_m = (txn >= 2);
        if (rxn > 0) begin
            rx_fmt_m     = (rxn >= 2);
            prev_rx      = rxw;
            prev_rx_long = rx_eff;
            have_rx      = 1'b1;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'h1b7a_05e3));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk(tx_slot_n == 1'b1, "R1 slot released", tx_slot_n, 1);
        chk(dec_start == 1'b0, "R1 no strobe", dec_start, 0);
        chk(dec_word == 8'h00, "R1 word zero", dec_word, 0);

        // directed: short, exact-two long, long, extended sync
        run_frame(1, 8'hA5, 1, 8'h3C, 1'b0);
        run_frame(1, 8'h81, 1, 8'hC3, 1'b0);
        run_frame(2, 8'h5A, 2, 8'h96, 1'b0);
        run_frame(2, 8'h0F, 2, 8'hF0, 1'b0);
        run_frame(3, 8'hE7, 3, 8'h18, 1'b0);
        run_frame(10, 8'h6B, 10, 8'h2D, 1'b0);
        run_frame(9, 8'hD2, 9, 8'h4E, 1'b0);
        run_frame(1, 8'h77, 1, 8'h11, 1'b0);
        // receive half-channel: own format, transmitter silent
        run_frame(0, 8'hFF, 3, 8'h99, 1'b1);
        run_frame(1, 8'hFF, 3, 8'h66, 1'b1);
        run_frame(0, 8'h00, 1, 8'hB4, 1'b1);
        run_frame(0, 8'h00, 1, 8'h4B, 1'b1);
        run_frame(0, 8'h00, 0, 8'h00, 1'b0);

        // random frames
        for (int i = 0; i < 40; i++) begin
            logic [7:0] tw = 8'($urandom);
            logic [7:0] rw = 8'($urandom);
            case ($urandom % 6)
                0: n = 1; 1: n = 2; 2: n = 3; 3: n = 4; 4: n = 9; default: n = 10;
            endcase
            if (($urandom % 5) == 0)
                run_frame(0, tw, (($urandom % 2) == 0) ? 1 : 3, rw, 1'b1);
            else
                run_frame(n, tw, n, rw, 1'b0);
        end
        run_frame(1, 8'h00, 1, 8'h00, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule